// File: doc/BRIEF.md
# Synthesizer Calibration and Fast-Lock Sequencer

This block orders the steps a fractional-N synthesizer loop goes through after each new frequency is programmed. A one-cycle trigger marks the write of the primary frequency word. If the synthesizer is powered, the trigger starts a band-calibration phase. During calibration the charge pump is held in high impedance and the VCO tuning node is switched over to a fixed reference. When the calibration time has elapsed, the block can run a timed fast-lock phase that uses a boosted pump-current code. It then settles in normal operation with the normal pump-current code.

All phase lengths are counted in ticks of a phase-detector-rate enable, `tick`, and not in system clock cycles. Calibration length grows exponentially with a 4-bit precision field. Fast-lock length grows linearly with a 4-bit timer field, in steps of 512. The block also sends a one-cycle reset to the lock detector and flags a prohibited calibration setting.

Top module: `cal_fastlock_seq`

## Requirements
- R1: After reset the block is in normal operation: `cal_busy`, `tune_ref`, `ld_clr` and `cfg_err` are 0, `cp_code` equals `cp_norm`, and `pump_hiz` follows `pump_hiz_req`.
- R2: A `freq_wr` pulse is accepted only when `pwr_en` is 1 and `lo_mode` is not 3 (3 selects an external local signal, with the synthesizer off). Otherwise the pulse has no effect, even while a phase is running.
- R3: Calibration lasts exactly (6 + 2^`cal_sel`) × 8 + 3 ticks. Ticks in the cycle of the accepted trigger are not counted, and clock cycles without `tick` do not advance the phase.
- R4: While calibration runs, `cal_busy`, `pump_hiz` and `tune_ref` are all 1.
- R5: If fast lock was enabled at the trigger, a fast-lock phase follows calibration. It lasts 511 + `fl_sel` × 512 ticks, drives `cp_code` = `cp_fast`, and holds `tune_ref` at 0.
- R6: If fast lock was disabled at the trigger, calibration leads straight to normal operation. In normal operation `cp_code` = `cp_norm` and `tune_ref` = 0.
- R7: While `pump_hiz_req` is 1, `pump_hiz` is 1 in every phase.
- R8: An accepted trigger with a valid `cal_sel` restarts calibration at its full length, whichever phase is running.
- R9: An accepted trigger with `cal_sel` of 0 or 12 to 15 sets `cfg_err`, leaves or aborts to normal operation, and produces no `ld_clr`. The next accepted valid trigger clears `cfg_err`.
- R10: `ld_clr` is a one-cycle pulse in the first cycle of each calibration.
- R11: `cal_sel`, `fl_en` and `fl_sel` are taken at the accepted trigger. Later changes to them do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Phase-detector-rate count enable |
| freq_wr | input | 1 | Pulse marking a write of the primary frequency word |
| pwr_en | input | 1 | Device enabled |
| lo_mode | input | 2 | Local operating mode; 3 = external local, synthesizer off |
| cal_sel | input | 4 | Calibration precision field (valid 1 to 11) |
| fl_en | input | 1 | Fast-lock enable |
| fl_sel | input | 4 | Fast-lock timer field |
| cp_norm | input | 3 | Normal pump-current code |
| cp_fast | input | 3 | Fast-lock pump-current code |
| pump_hiz_req | input | 1 | Software request to hold the pump in high impedance |
| cp_code | output | 3 | Pump-current code in use |
| pump_hiz | output | 1 | Pump high-impedance enable |
| tune_ref | output | 1 | Tuning node switched to the reference |
| cal_busy | output | 1 | Calibration in progress |
| ld_clr | output | 1 | One-cycle lock-detector reset |
| cfg_err | output | 1 | Last accepted trigger carried a prohibited `cal_sel` |

## Verification
The properties assume that `tick` and `freq_wr` are clean single-cycle-sampled levels, and that control fields change only between clock edges. The gating and restart properties also rely on `lo_mode` code 3 being the only mode that turns the synthesizer off. The bench drives every input on the falling edge and raises `freq_wr` for exactly one cycle with `tick` held low, so that each phase length can be counted tick by tick against the formulas. Tick spacing of one and three cycles checks that only ticks advance a phase.

// File: rtl/cal_fastlock_seq.sv
module cal_fastlock_seq #(
  parameter int CNT_W      = 15,
  parameter int CODE_W     = 3,
  parameter int SEL_W      = 4,
  parameter int CAL_MIN    = 1,
  parameter int CAL_MAX    = 11,
  parameter int CAL_BASE   = 6,
  parameter int CAL_SH     = 3,
  parameter int CAL_TAIL   = 3,
  parameter int FL_BASE    = 511,
  parameter int FL_STEP_SH = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              freq_wr,
  input  logic              pwr_en,
  input  logic [1:0]        lo_mode,
  input  logic [SEL_W-1:0]  cal_sel,
  input  logic              fl_en,
  input  logic [SEL_W-1:0]  fl_sel,
  input  logic [CODE_W-1:0] cp_norm,
  input  logic [CODE_W-1:0] cp_fast,
  input  logic              pump_hiz_req,
  output logic [CODE_W-1:0] cp_code,
  output logic              pump_hiz,
  output logic              tune_ref,
  output logic              cal_busy,
  output logic              ld_clr,
  output logic              cfg_err
);
  localparam logic [1:0] EXT_LO = 2'd3;

  typedef enum logic [1:0] {PH_NORM, PH_CAL, PH_FAST} phase_t;

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic              fl_en_q;
  logic [SEL_W-1:0]  fl_sel_q;
  logic              accept, sel_ok, last;
  logic [CNT_W-1:0]  cal_len, fl_len;

  assign accept  = freq_wr & pwr_en & (lo_mode != EXT_LO);
  assign sel_ok  = (int'(cal_sel) >= CAL_MIN) && (int'(cal_sel) <= CAL_MAX);
  assign cal_len = CNT_W'(((CAL_BASE + (1 << cal_sel)) << CAL_SH) + CAL_TAIL);
  assign fl_len  = CNT_W'(FL_BASE + (int'(fl_sel_q) << FL_STEP_SH));
  assign last    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_NORM;
      cnt      <= '0;
      fl_en_q  <= 1'b0;
      fl_sel_q <= '0;
      cfg_err  <= 1'b0;
      ld_clr   <= 1'b0;
    end else begin
      ld_clr <= 1'b0;
      if (accept) begin
        if (sel_ok) begin
          ph       <= PH_CAL;
          cnt      <= cal_len - CNT_W'(1);
          fl_en_q  <= fl_en;
          fl_sel_q <= fl_sel;
          cfg_err  <= 1'b0;
          ld_clr   <= 1'b1;
        end else begin
          ph      <= PH_NORM;
          cnt     <= '0;
          cfg_err <= 1'b1;
        end
      end else if (tick && ph != PH_NORM) begin
        if (!last) begin
          cnt <= cnt - CNT_W'(1);
        end else if (ph == PH_CAL && fl_en_q) begin
          ph  <= PH_FAST;
          cnt <= fl_len - CNT_W'(1);
        end else begin
          ph <= PH_NORM;
        end
      end
    end
  end

  assign cal_busy = (ph == PH_CAL);
  assign tune_ref = cal_busy;
  assign pump_hiz = cal_busy | pump_hiz_req;
  assign cp_code  = (ph == PH_FAST) ? cp_fast : cp_norm;
endmodule

// File: rtl/cal_fastlock_seq_chk.sv
module cal_fastlock_seq_chk #(
  parameter int CODE_W  = 3,
  parameter int SEL_W   = 4,
  parameter int CAL_MIN = 1,
  parameter int CAL_MAX = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              freq_wr,
  input logic              pwr_en,
  input logic [1:0]        lo_mode,
  input logic [SEL_W-1:0]  cal_sel,
  input logic              pump_hiz_req,
  input logic [CODE_W-1:0] cp_code,
  input logic              pump_hiz,
  input logic              tune_ref,
  input logic              cal_busy,
  input logic              ld_clr,
  input logic              cfg_err
);
  logic acc, good;
  assign acc  = freq_wr && pwr_en && (lo_mode != 2'd3);
  assign good = (int'(cal_sel) >= CAL_MIN) && (int'(cal_sel) <= CAL_MAX);

  // R4
  cal_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (pump_hiz && tune_ref));

  // R7
  hiz_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pump_hiz_req |-> pump_hiz);

  // R10
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_clr && !acc) |=> !ld_clr);

  // R10
  clr_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_clr |-> cal_busy);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && good) |=> (cal_busy && ld_clr && !cfg_err));

  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !good) |=> (cfg_err && !cal_busy && !ld_clr));

  // R2
  gated_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !cal_busy) |=> (!cal_busy && !ld_clr));

  // R3
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !tick && !acc) |=> cal_busy);
endmodule

bind cal_fastlock_seq cal_fastlock_seq_chk #(
  .CODE_W(CODE_W), .SEL_W(SEL_W), .CAL_MIN(CAL_MIN), .CAL_MAX(CAL_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .freq_wr(freq_wr), .pwr_en(pwr_en),
  .lo_mode(lo_mode), .cal_sel(cal_sel), .pump_hiz_req(pump_hiz_req),
  .cp_code(cp_code), .pump_hiz(pump_hiz), .tune_ref(tune_ref),
  .cal_busy(cal_busy), .ld_clr(ld_clr), .cfg_err(cfg_err)
);

// File: tb/cal_fastlock_seq_bench.sv
module cal_fastlock_seq_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tick = 1'b0, freq_wr = 1'b0, pwr_en = 1'b1, fl_en = 1'b0;
  logic [1:0] lo_mode = 2'd0;
  logic [3:0] cal_sel = 4'd1, fl_sel = 4'd0;
  logic [2:0] cp_norm = 3'd2, cp_fast = 3'd5;
  logic       pump_hiz_req = 1'b0;
  logic [2:0] cp_code;
  logic       pump_hiz, tune_ref, cal_busy, ld_clr, cfg_err;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  cal_fastlock_seq u_cal_fastlock_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freq_wr(freq_wr), .pwr_en(pwr_en),
    .lo_mode(lo_mode), .cal_sel(cal_sel), .fl_en(fl_en), .fl_sel(fl_sel),
    .cp_norm(cp_norm), .cp_fast(cp_fast), .pump_hiz_req(pump_hiz_req),
    .cp_code(cp_code), .pump_hiz(pump_hiz), .tune_ref(tune_ref),
    .cal_busy(cal_busy), .ld_clr(ld_clr), .cfg_err(cfg_err)
  );

  function automatic int cal_ticks(input int c);
    return (6 + (1 << c)) * 8 + 3;
  endfunction

  function automatic int fl_ticks(input int f);
    return 511 + f * 512;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] c, input logic fe, input logic [3:0] fs);
    cal_sel = c; fl_en = fe; fl_sel = fs; tick = 1'b0;
    freq_wr = 1'b1;
    @(negedge clk);
    freq_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  // kind 0: calibration phase, kind 1: fast-lock phase
  task automatic measure(input int kind, input int div, output int n, output int bad);
    int ph;
    n = 0; bad = 0; ph = 0;
    while ((kind == 0 ? cal_busy : (cp_code == cp_fast && !cal_busy)) && n <= 20000) begin
      if (kind == 0 && !(pump_hiz && tune_ref)) bad++;
      if (kind == 1 && (tune_ref || pump_hiz != pump_hiz_req)) bad++;
      tick = (ph == 0);
      ph = (ph + 1 == div) ? 0 : ph + 1;
      if (tick) n++;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "cal_busy", cal_busy, 0);
    chk("R1", "tune_ref", tune_ref, 0);
    chk("R1", "ld_clr", ld_clr, 0);
    chk("R1", "cfg_err", cfg_err, 0);
    chk("R1", "cp_code", cp_code, cp_norm);
    chk("R1", "pump_hiz", pump_hiz, 0);
  endtask

  task automatic t_cal_basic;
    int n, bad;
    fire(4'd1, 1'b0, 4'd0);
    chk("R10", "ld_clr first cycle", ld_clr, 1);
    chk("R4", "cal_busy", cal_busy, 1);
    @(negedge clk);
    chk("R10", "ld_clr second cycle", ld_clr, 0);
    chk("R3", "busy without tick", cal_busy, 1);
    measure(0, 1, n, bad);
    chk("R3", "cal length c=1", n, cal_ticks(1));
    chk("R4", "cal outputs", bad, 0);
    chk("R6", "normal code after cal", cp_code, cp_norm);
    chk("R6", "tune_ref after cal", tune_ref, 0);
    chk("R6", "pump_hiz after cal", pump_hiz, 0);
  endtask

  task automatic t_snapshot_div;
    int n, bad;
    fire(4'd3, 1'b0, 4'd0);
    cal_sel = 4'd11; fl_en = 1'b1; fl_sel = 4'd15;
    measure(0, 3, n, bad);
    chk("R11", "cal length c=3 after field change", n, cal_ticks(3));
    chk("R3", "cal outputs with sparse ticks", bad, 0);
    chk("R11", "no fast phase after fl_en change", cp_code, cp_norm);
  endtask

  task automatic t_fast;
    int n, bad;
    fire(4'd2, 1'b1, 4'd0);
    measure(0, 1, n, bad);
    chk("R3", "cal length c=2", n, cal_ticks(2));
    chk("R5", "fast code at entry", cp_code, cp_fast);
    measure(1, 2, n, bad);
    chk("R5", "fast length f=0", n, fl_ticks(0));
    chk("R5", "fast outputs", bad, 0);
    chk("R6", "normal code after fast", cp_code, cp_norm);
  endtask

  task automatic t_long;
    int n, bad;
    fire(4'd11, 1'b1, 4'd15);
    measure(0, 1, n, bad);
    chk("R3", "cal length c=11", n, cal_ticks(11));
    measure(1, 1, n, bad);
    chk("R5", "fast length f=15", n, fl_ticks(15));
  endtask

  task automatic t_restart;
    int n, bad;
    fire(4'd1, 1'b1, 4'd1);
    ticks(30);
    fire(4'd1, 1'b0, 4'd0);
    chk("R8", "ld_clr on restart in cal", ld_clr, 1);
    measure(0, 1, n, bad);
    chk("R8", "full cal after restart", n, cal_ticks(1));
    chk("R8", "restart took new fl_en", cp_code, cp_norm);
    fire(4'd1, 1'b1, 4'd0);
    measure(0, 1, n, bad);
    ticks(100);
    chk("R5", "still fast mid-phase", cp_code, cp_fast);
    fire(4'd1, 1'b1, 4'd0);
    chk("R8", "cal_busy on restart in fast", cal_busy, 1);
    chk("R8", "ld_clr on restart in fast", ld_clr, 1);
    measure(0, 1, n, bad);
    chk("R8", "cal length after fast restart", n, cal_ticks(1));
    measure(1, 1, n, bad);
    chk("R8", "fast length after restart", n, fl_ticks(0));
  endtask

  task automatic t_gate;
    int n, bad;
    lo_mode = 2'd3;
    fire(4'd1, 1'b0, 4'd0);
    chk("R2", "external-local mode ignored", cal_busy, 0);
    chk("R2", "no ld_clr in mode 3", ld_clr, 0);
    lo_mode = 2'd2;
    pwr_en = 1'b0;
    fire(4'd1, 1'b0, 4'd0);
    chk("R2", "disabled device ignored", cal_busy, 0);
    pwr_en = 1'b1;
    fire(4'd1, 1'b0, 4'd0);
    chk("R2", "mode 2 accepted", cal_busy, 1);
    ticks(30);
    pwr_en = 1'b0;
    fire(4'd1, 1'b0, 4'd0);
    pwr_en = 1'b1;
    chk("R2", "no ld_clr from blocked trigger", ld_clr, 0);
    measure(0, 1, n, bad);
    chk("R2", "blocked trigger left count", n, cal_ticks(1) - 30);
    lo_mode = 2'd0;
  endtask

  task automatic t_bad;
    fire(4'd1, 1'b1, 4'd0);
    ticks(10);
    fire(4'd12, 1'b0, 4'd0);
    chk("R9", "cfg_err on 12", cfg_err, 1);
    chk("R9", "cal aborted", cal_busy, 0);
    chk("R9", "no ld_clr on bad", ld_clr, 0);
    chk("R9", "normal code after abort", cp_code, cp_norm);
    ticks(600);
    chk("R9", "no fast after abort", cp_code, cp_norm);
    fire(4'd0, 1'b0, 4'd0);
    chk("R9", "cfg_err on 0", cfg_err, 1);
    chk("R9", "idle on 0", cal_busy, 0);
    fire(4'd5, 1'b0, 4'd0);
    chk("R9", "cfg_err cleared", cfg_err, 0);
    chk("R9", "cal after valid", cal_busy, 1);
    ticks(cal_ticks(5));
    chk("R3", "cal done c=5", cal_busy, 0);
  endtask

  task automatic t_hiz;
    int n, bad;
    pump_hiz_req = 1'b1;
    @(negedge clk);
    chk("R7", "hiz in normal", pump_hiz, 1);
    fire(4'd1, 1'b1, 4'd0);
    measure(0, 1, n, bad);
    chk("R7", "hiz in fast", pump_hiz, 1);
    measure(1, 1, n, bad);
    chk("R7", "fast outputs with hiz", bad, 0);
    pump_hiz_req = 1'b0;
    @(negedge clk);
    chk("R7", "hiz released in normal", pump_hiz, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cal_basic();
    t_snapshot_div();
    t_fast();
    t_long();
    t_restart();
    t_gate();
    t_bad();
    t_hiz();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule